// File: doc/BRIEF.md
# Parallel Printer Port Register File

This block is the host-side register file of a parallel printer port. A processor reaches it over a simple byte-wide register bus: a write strobe, a read strobe, an address of which only the three low bits are decoded, write data and registered read data. Three registers are visible: an outgoing data byte, a printer status byte and a control byte. Control writes do more than store a value. They run a printer-style handshake: the strobe edge hands the data byte to the printer side, the init line reloads status, and a strobe return with interrupts enabled raises a pending interrupt.

Successive status reads step the busy and acknowledge bits through the printer's response, so polling software sees a believable handshake without any real cable. A status read also clears the pending interrupt. A byte presented on the reverse-direction input is sampled every clock. When the direction bit is set, a data read returns that sampled byte instead of the outgoing one. The printer side receives each emitted byte as a one-cycle valid pulse with the byte beside it, and the interrupt leaves as a level.

Top module: `lpt_regfile`

## Requirements
- R1: After reset, the data byte is 0xFF, status is 0xD9, control is 0xCC, irq is 0, emit_valid is 0 and rd_data is 0x00.
- R2: Only addr[2:0] is decoded. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF. Writes to offsets 1 and 3 to 7 change nothing.
- R3: A control write stores the written value with bits 7:6 forced to 1. Control bits are: 5 direction, 4 interrupt enable, 3 select, 2 init (1 = not initialising), 1 auto-feed, 0 strobe.
- R4: A control write with bit 2 at 0 loads status with 0xD8. Status bits are: 7 not-busy, 6 ack, 5 paper-out, 4 online, 3 no-error, 0 timeout.
- R5: A control write with bits 2, 3 and 0 at 1 clears status bit 7. If the stored strobe bit was 0, the block also drives emit_valid high for one cycle after that write, with emit_byte equal to the data register.
- R6: A control write with bits 2 and 3 at 1 and bit 0 at 0 sets the pending interrupt if the stored control had bit 4 set. irq equals the pending flag from the clock edge that samples the access.
- R7: A status read returns the current status in rd_data on the next cycle and clears the pending interrupt.
- R8: When a status read sees status bit 7 and stored strobe both 0: if bit 6 is 1 it clears bit 6, otherwise it sets bits 6 and 7.
- R9: A data read returns the byte sampled from rev_byte on the previous clock when control bit 5 is 1, and the last written data byte otherwise.
- R10: When wr_en and rd_en are high together, the write is performed and the read is dropped, so rd_data holds its value.
- R11: A control write with bit 2 at 1 and bit 3 at 0 only stores control: status, pending flag and emit_valid are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | BUS_ADDR_W | Register address, low 3 bits decoded |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| rev_byte | input | 8 | Reverse-direction input byte, sampled every clock |
| emit_valid | output | 1 | One-cycle pulse: a byte is handed to the printer |
| emit_byte | output | 8 | Byte handed to the printer |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with BUS_ADDR_W at its default of 8. The address then carries five upper bits that must be ignored, so addresses such as 0x12 and 0xF8 can show that they alias onto the control and data registers. Offsets 3 to 7 are all reachable too, which covers the 0xFF read-back and the ignored writes. A behavioural model follows the handshake through strobe edges, init reloads, the ack/busy polling sequence and the interrupt set and clear, and its outputs are compared with the block on every clock.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int REG_W = 8;
    localparam int OFS_W = 3;

    localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

    // status bit positions
    localparam int ST_NBUSY = 7;
    localparam int ST_ACK   = 6;
    // control bit positions
    localparam int CT_DIR   = 5;
    localparam int CT_IEN   = 4;
    localparam int CT_SEL   = 3;
    localparam int CT_NINIT = 2;
    localparam int CT_STB   = 0;

    localparam logic [REG_W-1:0] CTRL_FORCE  = 8'hC0;
    localparam logic [REG_W-1:0] DATA_RST    = 8'hFF;
    localparam logic [REG_W-1:0] STAT_RST    = 8'hD9;
    localparam logic [REG_W-1:0] CTRL_RST    = 8'hCC;
    localparam logic [REG_W-1:0] STAT_INIT   = 8'hD8;
    localparam logic [REG_W-1:0] VOID_RDVAL  = 8'hFF;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DATA_WR,
        ACC_CTRL_WR,
        ACC_DATA_RD,
        ACC_STAT_RD,
        ACC_CTRL_RD,
        ACC_VOID_RD
    } acc_e;
endpackage

// File: rtl/lpt_decode.sv
module lpt_decode
    import lpt_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] ofs,
    output acc_e             acc
);
    always_comb begin
        acc = ACC_NONE;
        if (wr_en) begin
            unique case (ofs)
                OFS_DATA: acc = ACC_DATA_WR;
                OFS_CTRL: acc = ACC_CTRL_WR;
                default:  acc = ACC_NONE;
            endcase
        end else if (rd_en) begin
            unique case (ofs)
                OFS_DATA: acc = ACC_DATA_RD;
                OFS_STAT: acc = ACC_STAT_RD;
                OFS_CTRL: acc = ACC_CTRL_RD;
                default:  acc = ACC_VOID_RD;
            endcase
        end
    end
endmodule

// File: rtl/lpt_hshake.sv
module lpt_hshake
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  acc_e             acc,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] rev_byte,
    output logic [REG_W-1:0] data_q,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] rev_q,
    output logic             pend_q,
    output logic             emit_valid,
    output logic [REG_W-1:0] emit_byte
);
    logic [REG_W-1:0] ctrl_new;
    logic [REG_W-1:0] data_d, stat_d, ctrl_d, emit_byte_d;
    logic             pend_d, emit_d;

    assign ctrl_new = wdata | CTRL_FORCE;

    // next-state logic
    always_comb begin
        data_d      = data_q;
        stat_d      = stat_q;
        ctrl_d      = ctrl_q;
        pend_d      = pend_q;
        emit_d      = 1'b0;
        emit_byte_d = emit_byte;
        unique case (acc)
            ACC_DATA_WR: data_d = wdata;
            ACC_CTRL_WR: begin
                if (!ctrl_new[CT_NINIT]) begin
                    stat_d = STAT_INIT;
                end else if (ctrl_new[CT_SEL]) begin
                    if (ctrl_new[CT_STB]) begin
                        stat_d[ST_NBUSY] = 1'b0;
                        if (!ctrl_q[CT_STB]) begin
                            emit_d      = 1'b1;
                            emit_byte_d = data_q;
                        end
                    end else if (ctrl_q[CT_IEN]) begin
                        pend_d = 1'b1;
                    end
                end
                ctrl_d = ctrl_new;
            end
            ACC_STAT_RD: begin
                pend_d = 1'b0;
                if (!stat_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
                    if (stat_q[ST_ACK]) begin
                        stat_d[ST_ACK] = 1'b0;
                    end else begin
                        stat_d[ST_ACK]   = 1'b1;
                        stat_d[ST_NBUSY] = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= DATA_RST;
            stat_q     <= STAT_RST;
            ctrl_q     <= CTRL_RST;
            rev_q      <= DATA_RST;
            pend_q     <= 1'b0;
            emit_valid <= 1'b0;
            emit_byte  <= DATA_RST;
        end else begin
            data_q     <= data_d;
            stat_q     <= stat_d;
            ctrl_q     <= ctrl_d;
            rev_q      <= rev_byte;
            pend_q     <= pend_d;
            emit_valid <= emit_d;
            emit_byte  <= emit_byte_d;
        end
    end
endmodule

// File: rtl/lpt_regfile.sv
module lpt_regfile
    import lpt_pkg::*;
#(
    parameter int BUS_ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [BUS_ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rd_data,
    input  logic [REG_W-1:0]      rev_byte,
    output logic                  emit_valid,
    output logic [REG_W-1:0]      emit_byte,
    output logic                  irq
);
    acc_e             acc;
    logic [REG_W-1:0] data_q, stat_q, ctrl_q, rev_q;
    logic             pend_q;
    logic [REG_W-1:0] rd_mux;

    generate
        if (BUS_ADDR_W > OFS_W) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr[BUS_ADDR_W-1:OFS_W];
        end
    endgenerate

    lpt_decode u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .ofs   (addr[OFS_W-1:0]),
        .acc   (acc)
    );

    lpt_hshake u_hshake (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .wdata      (wdata),
        .rev_byte   (rev_byte),
        .data_q     (data_q),
        .stat_q     (stat_q),
        .ctrl_q     (ctrl_q),
        .rev_q      (rev_q),
        .pend_q     (pend_q),
        .emit_valid (emit_valid),
        .emit_byte  (emit_byte)
    );

    always_comb begin
        rd_mux = rd_data;
        unique case (acc)
            ACC_DATA_RD: rd_mux = ctrl_q[CT_DIR] ? rev_q : data_q;
            ACC_STAT_RD: rd_mux = stat_q;
            ACC_CTRL_RD: rd_mux = ctrl_q;
            ACC_VOID_RD: rd_mux = VOID_RDVAL;
            default:     rd_mux = rd_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_mux;
    end

    assign irq = pend_q;
endmodule

// File: rtl/lpt_regfile_chk.sv
module lpt_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] ofs,
    input logic [7:0] wdata,
    input logic [7:0] rd_data,
    input logic [7:0] stat_q,
    input logic       emit_valid,
    input logic       irq
);
    p_void_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && ofs >= 3'd3) |=> rd_data == 8'hFF);

    p_ctrl_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && ofs == 3'd2) |=> rd_data[7:6] == 2'b11);

    p_init_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == 3'd2 && !wdata[2]) |=> stat_q == 8'hD8);

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |=> !emit_valid);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en && ofs == 3'd2 && wdata[3:2] == 2'b11 && !wdata[0]));

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && ofs == 3'd1) |=> !irq);

    p_dual_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> $stable(rd_data));
endmodule

bind lpt_regfile lpt_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .ofs        (addr[2:0]),
    .wdata      (wdata),
    .rd_data    (rd_data),
    .stat_q     (stat_q),
    .emit_valid (emit_valid),
    .irq        (irq)
);

// File: tb/test_lpt_regfile.sv
`timescale 1ns/1ps
module test_lpt_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00, rev_byte = 8'h00;
    logic [7:0] rd_data, emit_byte;
    logic       emit_valid, irq;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_tag  = "R1";

    // reference model state
    logic [7:0] m_data, m_stat, m_ctrl, m_rev, m_rd, m_ebyte;
    logic       m_pend, m_evalid;

    always #5 clk = ~clk;

    lpt_regfile #(.BUS_ADDR_W(8)) i_lpt_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .rev_byte(rev_byte),
        .emit_valid(emit_valid), .emit_byte(emit_byte), .irq(irq)
    );

    // behavioural model of the register file
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_data = 8'hFF; m_stat = 8'hD9; m_ctrl = 8'hCC; m_rev = 8'hFF;
            m_rd = 8'h00; m_pend = 1'b0; m_evalid = 1'b0; m_ebyte = 8'hFF;
        end else begin
            int o;
            logic [7:0] v;
            o = int'(addr % 8);
            m_evalid = 1'b0;
            if (wr_en) begin
                if (o == 0) m_data = wdata;
                else if (o == 2) begin
                    v = wdata | 8'hC0;
                    if (v[2] == 1'b0) m_stat = 8'hD8;
                    else if (v[3]) begin
                        if (v[0]) begin
                            m_stat[7] = 1'b0;
                            if (m_ctrl[0] == 1'b0) begin
                                m_evalid = 1'b1;
                                m_ebyte  = m_data;
                            end
                        end else if (m_ctrl[4]) m_pend = 1'b1;
                    end
                    m_ctrl = v;
                end
            end else if (rd_en) begin
                case (o)
                    0: m_rd = m_ctrl[5] ? m_rev : m_data;
                    1: begin
                        m_rd = m_stat;
                        m_pend = 1'b0;
                        if (!m_stat[7] && !m_ctrl[0]) begin
                            if (m_stat[6]) m_stat[6] = 1'b0;
                            else begin m_stat[6] = 1'b1; m_stat[7] = 1'b1; end
                        end
                    end
                    2: m_rd = m_ctrl;
                    default: m_rd = 8'hFF;
                endcase
            end
            m_rev = rev_byte;
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("rd_data", rd_data, m_rd);
        chk("irq", {7'd0, irq}, {7'd0, m_pend});
        chk("emit_valid", {7'd0, emit_valid}, {7'd0, m_evalid});
        chk("emit_byte", emit_byte, m_ebyte);
    endtask

    // one bus cycle: compare at the falling edge, then drive
    task automatic cyc(logic w, logic r, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        compare_all();
        wr_en = w; rd_en = r; addr = a; wdata = d;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d); cyc(1'b1, 1'b0, a, d); endtask
    task automatic rd(logic [7:0] a);                cyc(1'b0, 1'b1, a, 8'h00); endtask
    task automatic idle();                           cyc(1'b0, 1'b0, 8'h00, 8'h00); endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cur_tag = "R1";
        idle(); rd(8'h00); rd(8'h01); rd(8'h02); idle();
        chk("ctrl reset readback", rd_data, 8'hCC);

        cur_tag = "R3";
        wr(8'h02, 8'h2C); rd(8'h02); idle();
        chk("ctrl forced bits", rd_data, 8'hEC);

        cur_tag = "R9";
        rev_byte = 8'h5A; idle(); rd(8'h00); idle();
        chk("reverse read", rd_data, 8'h5A);
        wr(8'h02, 8'h0C); rd(8'h00); idle();
        chk("forward read", rd_data, 8'hFF);
        wr(8'h00, 8'h33); rd(8'h00); idle();

        cur_tag = "R5";
        wr(8'h02, 8'h0D); idle();
        chk("emit pulse", {7'd0, emit_valid}, 8'h01);
        chk("emit byte", emit_byte, 8'h33);
        idle();
        wr(8'h02, 8'h0D); idle(); idle();

        cur_tag = "R8";
        rd(8'h01); wr(8'h02, 8'h0C); rd(8'h01); rd(8'h01); rd(8'h01); rd(8'h01); idle();
        chk("status after sequence", rd_data, 8'hD9);

        cur_tag = "R6";
        wr(8'h00, 8'hA5); wr(8'h02, 8'h1D); wr(8'h02, 8'h1C); idle();
        chk("irq raised", {7'd0, irq}, 8'h01);
        idle();
        cur_tag = "R7";
        rd(8'h01); idle();
        chk("irq cleared", {7'd0, irq}, 8'h00);

        cur_tag = "R11";
        wr(8'h02, 8'h15); wr(8'h02, 8'h14); wr(8'h02, 8'h15); rd(8'h01); idle();

        cur_tag = "R4";
        wr(8'h02, 8'h08); rd(8'h01); idle();
        chk("init load", rd_data, 8'hD8);

        cur_tag = "R2";
        for (int k = 3; k < 8; k++) begin rd(8'(k)); idle(); end
        wr(8'h01, 8'h00); wr(8'h05, 8'h77); rd(8'h01); rd(8'h12); wr(8'hF8, 8'h6E);
        wr(8'h02, 8'h0C); rd(8'h00); idle();
        chk("alias data write", rd_data, 8'h6E);

        cur_tag = "R10";
        rd(8'h02); cyc(1'b1, 1'b1, 8'h00, 8'h44); idle(); rd(8'h00); idle();
        chk("write kept in dual access", rd_data, 8'h44);

        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule